// File: doc/BRIEF.md
# Shared-MAC Complex LMS Filter Engine

This block runs one adaptive complex FIR filter on behalf of several users, one pass at a time. A caller names a user, picks train or detect, pulses `start`, and then streams N complex samples, one per cycle. The engine multiplies the user's stored coefficients against those samples on a single shared multiplier and returns the real part of the conjugate-weighted inner product. In train mode it also forms the error against a ±1 training symbol and writes an updated coefficient row back for that user.

Samples and coefficients are 16-bit two's-complement values with FRAC fractional bits (12 by default, so +1.0 is 4096). The step size is 2^-MU_SH and costs only a shift. Each pass has a fixed cycle count, so a scheduler above the block can budget any number of users without any handshake.

Top module: `lms_mux_pe`

## Requirements
- R1: After reset, `busy`, `y_valid` and `y_re` are 0 and every coefficient of every user is zero, so a detect pass on an untouched user returns 0.
- R2: The result is sat16(floor(S / 2^FRAC)), where S = Σ over taps t of (wr[t]·xr[t] + wi[t]·xi[t]) is accumulated without loss and sat16 clamps to [-32768, 32767].
- R3: A detect pass keeps `busy` high for exactly 2N+4 cycles and leaves every coefficient unchanged.
- R4: A train pass keeps `busy` high for exactly 2N+5 cycles. In both modes `y_valid` is a one-cycle pulse in the 2N+5th cycle after the start-accept edge.
- R5: In train mode the error is e = sat16(d − y), where d = +2^FRAC when `train_sym` is 1 and −2^FRAC when it is 0.
- R6: A train pass replaces each coefficient w of the user with sat16(w + floor(e·x / 2^(FRAC+MU_SH))), where x is the matching sample part (real with real, imaginary with imaginary).
- R7: Each user has its own coefficient row. A pass reads and writes only the row of the user latched at start.
- R8: `start` raised while `busy` is high is ignored: the running pass keeps its length, user and result, and no second pass follows.
- R9: Sample t is taken in the t-th cycle after the start-accept edge (t = 0..N−1). If `s_valid` is low in that cycle, the sample counts as zero.
- R10: A new `start` is accepted in the first cycle with `busy` low. A pass that starts there sees the coefficients written by the pass just before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass; taken only when not busy |
| mode | input | 1 | 1 = train and update, 0 = detect only |
| user | input | $clog2(USERS) | User whose coefficient row is used |
| train_sym | input | 1 | Training symbol: 1 for +1, 0 for −1 |
| s_valid | input | 1 | Sample present this cycle |
| s_re | input | DW | Sample real part |
| s_im | input | DW | Sample imaginary part |
| busy | output | 1 | High for the whole pass |
| y_valid | output | 1 | One-cycle result strobe |
| y_re | output | DW | Real filter output |

## Verification
Two events can land in the same cycle. The first is the coefficient write-back that closes a train pass together with the start of the next pass for the same user. The second is the result strobe of a detect pass together with a new start request. The bench chains passes by raising `start` in the very first idle cycle, so the next pass's reads land right behind the write. Its result is judged against an arithmetic model that has already applied the previous update. A separate pass raises `start` for another user in mid-pass; the bench then checks that the pass length, the result and the idle state afterwards are unchanged.

// File: rtl/lmspe_pkg.sv
package lmspe_pkg;

  typedef enum logic {
    PM_DETECT = 1'b0,
    PM_TRAIN  = 1'b1
  } pe_mode_e;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_RUN  = 1'b1
  } ctl_state_e;

endpackage

// File: rtl/lmspe_ctrl.sv
module lmspe_ctrl
  import lmspe_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned USERS = 4,
  parameter int unsigned UW    = $clog2(USERS),
  parameter int unsigned CW    = $clog2(2*N+6)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_in,
  input  logic [UW-1:0] user_in,
  output logic          run,
  output logic          accept,
  output pe_mode_e      mode_q,
  output logic [UW-1:0] user_q,
  output logic [CW-1:0] cnt,
  output logic          cap_en,
  output logic          issue,
  output logic          load_y,
  output logic          upd_en
);

  localparam logic [CW-1:0] DET_LAST = CW'(2*N+3);
  localparam logic [CW-1:0] TRN_LAST = CW'(2*N+4);
  localparam logic [CW-1:0] ISS_HI   = CW'(2*N);
  localparam logic [CW-1:0] NSAMP    = CW'(N);

  ctl_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_c;

  assign last_c = (mode_q == PM_TRAIN) ? TRN_LAST : DET_LAST;
  assign accept = (state_q == CS_IDLE) && start;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      CS_IDLE: begin
        if (start) begin
          state_d = CS_RUN;
          cnt_d   = '0;
        end
      end
      CS_RUN: begin
        if (cnt_q == last_c) begin
          state_d = CS_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_DETECT;
      user_q <= '0;
    end else if (accept) begin
      mode_q <= pe_mode_e'(mode_in);
      user_q <= user_in;
    end
  end

  assign run    = (state_q == CS_RUN);
  assign cnt    = cnt_q;
  assign cap_en = run && (cnt_q < NSAMP);
  assign issue  = run && (cnt_q != '0) && (cnt_q <= ISS_HI);
  assign load_y = run && (cnt_q == DET_LAST);
  assign upd_en = run && (mode_q == PM_TRAIN) && (cnt_q == TRN_LAST);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q == last_c) |=> !run);

  // R4
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && cnt_q != last_c) |=>
      (run && cnt_q == $past(cnt_q) + 1'b1 && user_q == $past(user_q)));

endmodule

// File: rtl/lmspe_mac.sv
module lmspe_mac #(
  parameter int unsigned DW   = 16,
  parameter int unsigned N    = 4,
  parameter int unsigned FRAC = 12,
  parameter int unsigned PW   = 2*DW,
  parameter int unsigned AW   = PW + $clog2(2*N) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] op_a,
  input  logic signed [DW-1:0] op_b,
  output logic signed [DW-1:0] y_sat
);

  localparam logic signed [AW-1:0] HI = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] LO = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] p1_q, p2_q;
  logic                 v1_q, v2_q;
  logic signed [AW-1:0] acc_q, acc_d;
  logic signed [AW-1:0] acc_sh;

  // two-stage multiplier
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_q <= '0;
      p2_q <= '0;
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      p1_q <= op_a * op_b;
      p2_q <= p1_q;
      v1_q <= in_valid;
      v2_q <= v1_q;
    end
  end

  always_comb begin
    acc_d = acc_q;
    if (clr)       acc_d = '0;
    else if (v2_q) acc_d = acc_q + AW'(p2_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  always_comb begin
    acc_sh = acc_q >>> FRAC;
    if (acc_sh > HI)      y_sat = HI[DW-1:0];
    else if (acc_sh < LO) y_sat = LO[DW-1:0];
    else                  y_sat = acc_sh[DW-1:0];
  end

endmodule

// File: rtl/lmspe_coef.sv
module lmspe_coef #(
  parameter int unsigned DW    = 16,
  parameter int unsigned N     = 4,
  parameter int unsigned USERS = 4,
  parameter int unsigned FRAC  = 12,
  parameter int unsigned MU_SH = 3,
  parameter int unsigned UW    = $clog2(USERS),
  parameter int unsigned PW    = 2*DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [UW-1:0]        sel_user,
  input  logic                 upd_en,
  input  logic signed [DW-1:0] err,
  input  logic signed [DW-1:0] x_re [N],
  input  logic signed [DW-1:0] x_im [N],
  output logic signed [DW-1:0] w_re [N],
  output logic signed [DW-1:0] w_im [N]
);

  localparam int unsigned SH = FRAC + MU_SH;
  localparam logic signed [PW-1:0] HI = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] LO = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [DW-1:0] mem_re [USERS][N];
  logic signed [DW-1:0] mem_im [USERS][N];
  logic signed [DW-1:0] nw_re  [N];
  logic signed [DW-1:0] nw_im  [N];

  function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] v);
    if (v > HI)      return HI[DW-1:0];
    else if (v < LO) return LO[DW-1:0];
    else             return v[DW-1:0];
  endfunction

  for (genvar t = 0; t < N; t++) begin : g_tap
    logic signed [PW-1:0] dre, dim;
    assign w_re[t] = mem_re[sel_user][t];
    assign w_im[t] = mem_im[sel_user][t];
    assign dre = (err * x_re[t]) >>> SH;
    assign dim = (err * x_im[t]) >>> SH;
    assign nw_re[t] = clip(PW'(w_re[t]) + dre);
    assign nw_im[t] = clip(PW'(w_im[t]) + dim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < USERS; u++) begin
        for (int t = 0; t < N; t++) begin
          mem_re[u][t] <= '0;
          mem_im[u][t] <= '0;
        end
      end
    end else if (upd_en) begin
      for (int t = 0; t < N; t++) begin
        mem_re[sel_user][t] <= nw_re[t];
        mem_im[sel_user][t] <= nw_im[t];
      end
    end
  end

  for (genvar u = 0; u < USERS; u++) begin : g_uchk
    for (genvar t = 0; t < N; t++) begin : g_tchk
      // R7
      row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_en && sel_user == UW'(u)) |=>
          ($stable(mem_re[u][t]) && $stable(mem_im[u][t])));
    end
  end

endmodule

// File: rtl/lms_mux_pe.sv
module lms_mux_pe
  import lmspe_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned N     = 4,
  parameter int unsigned USERS = 4,
  parameter int unsigned FRAC  = 12,
  parameter int unsigned MU_SH = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       mode,
  input  logic [$clog2(USERS)-1:0]   user,
  input  logic                       train_sym,
  input  logic                       s_valid,
  input  logic signed [DW-1:0]       s_re,
  input  logic signed [DW-1:0]       s_im,
  output logic                       busy,
  output logic                       y_valid,
  output logic signed [DW-1:0]       y_re
);

  localparam int unsigned UW = $clog2(USERS);
  localparam int unsigned CW = $clog2(2*N+6);
  localparam int unsigned TW = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned EW = DW + 2;
  localparam logic signed [EW-1:0] ONE = EW'(1) <<< FRAC;
  localparam logic signed [EW-1:0] EHI = {3'b000, {(DW-1){1'b1}}};
  localparam logic signed [EW-1:0] ELO = {3'b111, {(DW-1){1'b0}}};

  logic          run, accept, cap_en, issue, load_y, upd_en;
  pe_mode_e      mode_q;
  logic [UW-1:0] user_q;
  logic [CW-1:0] cnt, k_idx;
  logic [TW-1:0] tap;
  logic          part, sym_q;

  logic signed [DW-1:0] x_re [N];
  logic signed [DW-1:0] x_im [N];
  logic signed [DW-1:0] w_re [N];
  logic signed [DW-1:0] w_im [N];
  logic signed [DW-1:0] op_a, op_b, y_sat, y_q, err_q, err_d;
  logic signed [EW-1:0] e_wide, d_val;
  logic                 yv_q;

  lmspe_ctrl #(.N(N), .USERS(USERS), .UW(UW), .CW(CW)) u_ctrl (
    .clk, .rst_n, .start, .mode_in(mode), .user_in(user),
    .run, .accept, .mode_q, .user_q, .cnt, .cap_en, .issue, .load_y, .upd_en
  );

  // sample buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < N; t++) begin
        x_re[t] <= '0;
        x_im[t] <= '0;
      end
    end else if (cap_en) begin
      x_re[TW'(cnt)] <= s_valid ? s_re : '0;
      x_im[TW'(cnt)] <= s_valid ? s_im : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sym_q <= 1'b0;
    else if (accept) sym_q <= train_sym;
  end

  // operand steering: two products per tap, real then imaginary
  always_comb begin
    k_idx = cnt - 1'b1;
    tap   = TW'(k_idx >> 1);
    part  = k_idx[0];
    op_a  = '0;
    op_b  = '0;
    if (issue) begin
      op_a = part ? w_im[tap] : w_re[tap];
      op_b = part ? x_im[tap] : x_re[tap];
    end
  end

  lmspe_mac #(.DW(DW), .N(N), .FRAC(FRAC)) u_mac (
    .clk, .rst_n, .clr(accept), .in_valid(issue),
    .op_a, .op_b, .y_sat
  );

  lmspe_coef #(.DW(DW), .N(N), .USERS(USERS), .FRAC(FRAC), .MU_SH(MU_SH), .UW(UW)) u_coef (
    .clk, .rst_n, .sel_user(user_q), .upd_en, .err(err_q),
    .x_re, .x_im, .w_re, .w_im
  );

  // error against the training symbol
  always_comb begin
    d_val  = sym_q ? ONE : -ONE;
    e_wide = d_val - EW'(y_sat);
    if (e_wide > EHI)      err_d = EHI[DW-1:0];
    else if (e_wide < ELO) err_d = ELO[DW-1:0];
    else                   err_d = e_wide[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q   <= '0;
      err_q <= '0;
      yv_q  <= 1'b0;
    end else begin
      yv_q <= load_y;
      if (load_y) begin
        y_q   <= y_sat;
        err_q <= err_d;
      end
    end
  end

  assign busy    = run;
  assign y_valid = yv_q;
  assign y_re    = y_q;

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |=> !y_valid);

  // R3
  detect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == PM_DETECT) |-> !upd_en);

endmodule

// File: tb/tb_lms_mux_pe.sv
`timescale 1ns/1ps
module tb_lms_mux_pe;

  localparam int DW = 16, N = 4, USERS = 4, FRAC = 12, MU_SH = 3;
  localparam int UW = $clog2(USERS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, train_sym = 1'b0, s_valid = 1'b0;
  logic [UW-1:0] user = '0;
  logic signed [DW-1:0] s_re = '0, s_im = '0;
  logic busy, y_valid;
  logic signed [DW-1:0] y_re;

  int checks = 0, errors = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  longint mwr [USERS][N];
  longint mwi [USERS][N];
  int  xr [N];
  int  xi [N];
  bit  vm [N];

  always #10 clk = ~clk;

  lms_mux_pe #(.DW(DW), .N(N), .USERS(USERS), .FRAC(FRAC), .MU_SH(MU_SH)) dut (
    .clk, .rst_n, .start, .mode, .user, .train_sym,
    .s_valid, .s_re, .s_im, .busy, .y_valid, .y_re
  );

  function automatic longint sat16(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[31:16]));
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fill(int shift);
    for (int t = 0; t < N; t++) begin
      xr[t] = rnd16() >>> shift;
      xi[t] = rnd16() >>> shift;
      vm[t] = 1'b1;
    end
  endtask

  task automatic run_pass(bit tr, int u, bit sym, bit chain, bit poke, string tag);
    longint acc, yexp, eexp;
    int bc, ycyc;
    longint ygot;
    bit seen;
    acc = 0; bc = 0; ycyc = -1; ygot = 0; seen = 0;
    for (int t = 0; t < N; t++)
      if (vm[t]) acc += mwr[u][t] * xr[t] + mwi[u][t] * xi[t];
    yexp = sat16(acc >>> FRAC);
    eexp = sat16((sym ? 64'sd4096 : -64'sd4096) - yexp);
    if (!chain) @(negedge clk);
    start = 1'b1; mode = tr; user = UW'(u); train_sym = sym;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 64; k++) begin
      if (k < N) begin
        s_valid = vm[k]; s_re = DW'(xr[k]); s_im = DW'(xi[k]);
      end else begin
        s_valid = 1'b0; s_re = '0; s_im = '0;
      end
      if (poke) begin
        start = (k == 3);
        user  = UW'((u + 1) % USERS);
      end
      if (y_valid) begin
        seen = 1; ygot = y_re; ycyc = k;
      end
      if (!busy) break;
      bc++;
      @(negedge clk);
    end
    chk(bc == (tr ? 2*N+5 : 2*N+4), tr ? "R4 busy length" : "R3 busy length",
        bc, tr ? 2*N+5 : 2*N+4);
    chk(seen && ycyc == 2*N+4, "R4 strobe cycle", ycyc, 2*N+4);
    chk(ygot == yexp, {tag, " R2 result"}, ygot, yexp);
    if (tr) begin
      for (int t = 0; t < N; t++) begin
        longint xre, xim;
        xre = vm[t] ? xr[t] : 0;
        xim = vm[t] ? xi[t] : 0;
        mwr[u][t] = sat16(mwr[u][t] + ((eexp * xre) >>> (FRAC + MU_SH)));
        mwi[u][t] = sat16(mwi[u][t] + ((eexp * xim) >>> (FRAC + MU_SH)));
      end
    end
  endtask

  initial begin
    for (int u = 0; u < USERS; u++)
      for (int t = 0; t < N; t++) begin
        mwr[u][t] = 0; mwi[u][t] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(y_valid == 1'b0, "R1 y_valid", y_valid, 0);
    chk(y_re == 0, "R1 y_re", y_re, 0);

    // R1 zero coefficients: detect on fresh user yields 0
    fill(0);
    run_pass(0, 0, 1, 0, 0, "R1");

    // R5 R6 R10: training sweep over all users, every other pass chained
    for (int u = 0; u < USERS; u++) begin
      for (int it = 0; it < 8; it++) begin
        fill(it % 3);
        run_pass(1, u, it[0] ^ u[0], it[0], 0, it[0] ? "R10 R5 R6" : "R5 R6");
      end
    end

    // R3 R7: detect each user twice; rows must be distinct and unchanged
    for (int u = 0; u < USERS; u++) begin
      fill(1);
      run_pass(0, u, 0, 0, 0, "R7");
      run_pass(0, u, 0, 1, 0, "R3 R10");
    end

    // R8: start for another user in mid-pass is ignored
    fill(1);
    run_pass(1, 1, 1, 0, 1, "R8");
    @(negedge clk);
    chk(busy == 1'b0, "R8 no extra pass", busy, 0);
    fill(1);
    run_pass(0, 2, 0, 0, 0, "R8 other row");

    // R9: dropped sample beats count as zero
    for (int m = 1; m < (1 << N); m += 3) begin
      fill(0);
      for (int t = 0; t < N; t++) vm[t] = m[t];
      run_pass(1, 3, m[0], 0, 0, "R9");
    end
    fill(0);
    run_pass(0, 3, 0, 0, 0, "R9 after");

    // R5 R6 saturation: full-scale inputs drive error and coefficients to the rails
    for (int it = 0; it < 10; it++) begin
      for (int t = 0; t < N; t++) begin
        xr[t] = (it % 2) ? -32768 : 32767;
        xi[t] = (t % 2) ? 32767 : -32768;
        vm[t] = 1'b1;
      end
      run_pass(1, 0, it < 5, it[0], 0, "R5 R6 sat");
    end
    fill(0);
    run_pass(0, 0, 0, 0, 0, "R2 sat");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule